// File: doc/BRIEF.md
# Audio Receive Sample FIFO

This block buffers stereo sample pairs coming from a serial audio receiver and presents them to a host on a 32-bit read port. Each pair the receiver delivers is written in one cycle. The host then drains the buffer in one of four stereo layouts:

- **Dual:** two reads per pair, left first.
- **16-bit packed:** both channels in one word.
- **8-bit packed:** both channels in the low half-word.
- **Mono:** one channel per read.

The packing is applied on the read side, so the stored pairs stay in full width whatever layout is selected.

A sample-count level tracks the buffer. A pair counts as two samples, and a mono entry also counts as two. A half-consumed pair in dual layout leaves the level odd. A service request is raised while the level is above a programmable threshold, and the threshold's lowest bit always reads back as one. A pair that arrives when the buffer is full is dropped, and a sticky error flag records the loss.

Top module: `audio_rx_fifo`

## Requirements
- R1: After reset, the level is 0, the request is low, the error flag is low, the threshold reads back as 1 and the read data is 0.
- R2: Each accepted pair raises the level by 2. The buffer holds 8 pairs, so the level never exceeds 16.
- R3: In dual layout (mode 0), the first read of a pair returns the full left sample and lowers the level by 1, which leaves it odd. The second read returns the right sample and lowers the level by 1 more.
- R4: In 16-bit packed layout (mode 1), one read returns left[15:0] in bits 15:0 and right[15:0] in bits 31:16, and lowers the level by 2.
- R5: In 8-bit packed layout (mode 2), one read returns left[7:0] in bits 7:0 and right[7:0] in bits 15:8, with bits 31:16 zero, and lowers the level by 2.
- R6: In mono layout (mode 3), one read returns the full left sample, discards the right sample and lowers the level by 2.
- R7: The request is high exactly while the level is greater than the written threshold with its bit 0 taken as 0. A threshold of 0 requests on any data, and a threshold of 16 never requests.
- R8: The threshold reads back with bits 4:1 as written and bit 0 forced to 1. It is 0 after reset.
- R9: A pair that arrives while 8 pairs are stored is discarded. The stored contents are kept, and the error flag becomes 1 and stays 1 until reset.
- R10: A read while the buffer is empty returns 0 and leaves the level unchanged.
- R11: Pairs are read out in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Read layout: 0 dual, 1 16-bit packed, 2 8-bit packed, 3 mono |
| pair_valid_i | input | 1 | A received pair is offered this cycle |
| left_i | input | 32 | Left sample of the offered pair |
| right_i | input | 32 | Right sample of the offered pair |
| rd_en_i | input | 1 | Consume the word shown on rd_data_o |
| rd_data_o | output | 32 | Formatted head word, 0 when empty |
| thr_wr_i | input | 1 | Write the threshold |
| thr_i | input | 5 | New threshold value |
| thr_o | output | 5 | Threshold readback, bit 0 always 1 |
| level_o | output | 5 | Stored sample count |
| req_o | output | 1 | Service request |
| rx_err_o | output | 1 | Sticky dropped-pair flag |

## Verification
The bench targets the following corner cases; for each one it notes what a faulty design would do.

- **Half-read pair in dual layout.** The bench checks for the odd level after the left read. A design that pops on the first read would show an even level and lose the right sample.
- **Packed layouts.** The bench drives the unused high sample bits with garbage. A design with a wrong field position or a missing zero-fill would leak those bits into the read word.
- **Threshold.** The bench covers the boundary where the level equals the threshold, threshold values written with bit 0 set, and the extremes 0 and 16. An off-by-one comparison or a threshold that uses bit 0 would move the request edge.
- **Full-buffer push and empty read.** The bench checks that a ninth pair leaves the level at 16, sets the flag for good and does not overwrite the oldest pair. It also checks that a read of an empty buffer neither underflows the level nor returns stale data.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    LAY_DUAL  = 2'd0,
    LAY_PK16  = 2'd1,
    LAY_PK8   = 2'd2,
    LAY_MONO  = 2'd3
  } layout_e;

  // Samples held in the buffer: every stored pair weighs two, minus one
  // when its left half has already been handed out.
  function automatic int unsigned samples_held(int unsigned pairs, logic half_taken);
    return 2 * pairs - (half_taken ? 1 : 0);
  endfunction

  // Word presented to the host for the head pair in the given layout.
  function automatic logic [WORD_W-1:0] shape_word(layout_e lay,
                                                   logic [WORD_W-1:0] l,
                                                   logic [WORD_W-1:0] r,
                                                   logic half_taken);
    case (lay)
      LAY_DUAL: return half_taken ? r : l;
      LAY_PK16: return {r[15:0], l[15:0]};
      LAY_PK8:  return {16'h0000, r[7:0], l[7:0]};
      default:  return l;
    endcase
  endfunction
endpackage

// File: rtl/rx_pair_store.sv
module rx_pair_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PAIRS  = 8,
  localparam int unsigned PTR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1,
  localparam int unsigned CNT_W = $clog2(PAIRS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wr_l,
  input  logic [DATA_W-1:0] wr_r,
  output logic [DATA_W-1:0] head_l,
  output logic [DATA_W-1:0] head_r,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem_l [PAIRS];
  logic [DATA_W-1:0] mem_r [PAIRS];
  logic [PTR_W-1:0]  wp, rp;

  assign full   = (count == CNT_W'(PAIRS));
  assign empty  = (count == '0);
  assign head_l = mem_l[rp];
  assign head_r = mem_r[rp];

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(PAIRS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      mem_l[wp] <= wr_l;
      mem_r[wp] <= wr_r;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(PAIRS));
endmodule

// File: rtl/rx_read_shaper.sv
module rx_read_shaper
  import audio_rx_pkg::*;
#(
  parameter int unsigned PAIRS = 8,
  localparam int unsigned CNT_W = $clog2(PAIRS + 1),
  localparam int unsigned LVL_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  layout_e           lay,
  input  logic              rd_en,
  input  logic              empty,
  input  logic [CNT_W-1:0]  count,
  input  logic [WORD_W-1:0] head_l,
  input  logic [WORD_W-1:0] head_r,
  output logic              pop,
  output logic [WORD_W-1:0] rd_data,
  output logic [LVL_W-1:0]  level
);
  logic half_q;
  logic take;

  assign take    = rd_en && !empty;
  assign pop     = take && (lay != LAY_DUAL || half_q);
  assign rd_data = empty ? '0 : shape_word(lay, head_l, head_r, half_q);
  assign level   = LVL_W'(samples_held(int'(count), half_q));

  always_ff @(posedge clk) begin
    if (!rst_n)    half_q <= 1'b0;
    else if (take) half_q <= (lay == LAY_DUAL) ? !half_q : 1'b0;
  end

  assert_pop_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/rx_threshold.sv
module rx_threshold #(
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [LVL_W-1:0] thr_in,
  input  logic [LVL_W-1:0] level,
  output logic [LVL_W-1:0] thr_rd,
  output logic             req
);
  logic [LVL_W-1:0] thr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  thr_q <= '0;
    else if (wr) thr_q <= thr_in & ~LVL_W'(1);
  end

  assign thr_rd = thr_q | LVL_W'(1);
  assign req    = level > thr_q;

  assert_req_quiet_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> !req);
endmodule

// File: rtl/audio_rx_fifo.sv
module audio_rx_fifo
  import audio_rx_pkg::*;
#(
  parameter int unsigned PAIRS = 8,
  localparam int unsigned CNT_W = $clog2(PAIRS + 1),
  localparam int unsigned LVL_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              pair_valid_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              thr_wr_i,
  input  logic [LVL_W-1:0]  thr_i,
  output logic [LVL_W-1:0]  thr_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              req_o,
  output logic              rx_err_o
);
  logic [WORD_W-1:0] head_l, head_r;
  logic [CNT_W-1:0]  count;
  logic              full, empty;
  logic              pop_evt;
  logic              push_ok;
  logic              drop_evt;
  layout_e           lay;

  assign lay      = layout_e'(mode_i);
  assign push_ok  = pair_valid_i && !full;
  assign drop_evt = pair_valid_i && full;

  rx_pair_store #(.DATA_W(WORD_W), .PAIRS(PAIRS)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push_ok), .pop(pop_evt),
    .wr_l(left_i), .wr_r(right_i), .head_l(head_l), .head_r(head_r),
    .count(count), .full(full), .empty(empty)
  );

  rx_read_shaper #(.PAIRS(PAIRS)) u_shape (
    .clk(clk), .rst_n(rst_n), .lay(lay), .rd_en(rd_en_i), .empty(empty),
    .count(count), .head_l(head_l), .head_r(head_r), .pop(pop_evt),
    .rd_data(rd_data_o), .level(level_o)
  );

  rx_threshold #(.LVL_W(LVL_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .wr(thr_wr_i), .thr_in(thr_i),
    .level(level_o), .thr_rd(thr_o), .req(req_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        rx_err_o <= 1'b0;
    else if (drop_evt) rx_err_o <= 1'b1;
  end

  assert_level_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= LVL_W'(2 * PAIRS));
  assert_push_adds_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !rd_en_i) |=> level_o == $past(level_o) + LVL_W'(2));
  assert_left_read_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && lay == LAY_DUAL && level_o != '0 && !level_o[0] && !pair_valid_i)
    |=> level_o[0]);
  assert_drop_sets_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && !rd_en_i) |=> rx_err_o && $stable(level_o));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_o |=> rx_err_o);
  assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && level_o == '0 && !pair_valid_i) |=> level_o == '0);
endmodule

// File: tb/audio_rx_fifo_bench.sv
module audio_rx_fifo_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        pair_valid_i = 1'b0;
  logic [31:0] left_i = '0, right_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        thr_wr_i = 1'b0;
  logic [4:0]  thr_i = '0;
  logic [4:0]  thr_o, level_o;
  logic        req_o, rx_err_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_rx_fifo u_audio_rx_fifo (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .pair_valid_i(pair_valid_i),
    .left_i(left_i), .right_i(right_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
    .thr_wr_i(thr_wr_i), .thr_i(thr_i), .thr_o(thr_o), .level_o(level_o),
    .req_o(req_o), .rx_err_o(rx_err_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(logic [31:0] l, logic [31:0] r);
    pair_valid_i = 1'b1; left_i = l; right_i = r;
    @(negedge clk);
    pair_valid_i = 1'b0;
  endtask

  task automatic pull(output logic [31:0] word);
    word = rd_data_o;
    rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic set_thr(logic [4:0] v);
    thr_i = v; thr_wr_i = 1'b1;
    @(negedge clk);
    thr_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 level", 32'(level_o), 0);
    check("R1 req", 32'(req_o), 0);
    check("R1 err", 32'(rx_err_o), 0);
    check("R1 thr", 32'(thr_o), 1);
    check("R1 data", rd_data_o, 0);
  endtask

  task automatic t_dual();
    logic [31:0] w;
    mode_i = 2'd0;
    push(32'hA1A1_0001, 32'hB1B1_0001);
    push(32'hA2A2_0002, 32'hB2B2_0002);
    check("R2 level after two pairs", 32'(level_o), 4);
    pull(w); check("R3 left first", w, 32'hA1A1_0001);
    check("R3 odd level", 32'(level_o), 3);
    pull(w); check("R3 right second", w, 32'hB1B1_0001);
    check("R3 level", 32'(level_o), 2);
    pull(w); check("R11 order left", w, 32'hA2A2_0002);
    pull(w); check("R11 order right", w, 32'hB2B2_0002);
    check("R3 drained", 32'(level_o), 0);
  endtask

  task automatic t_pk16();
    logic [31:0] w;
    mode_i = 2'd1;
    push(32'hDEAD_1234, 32'hBEEF_5678);
    pull(w); check("R4 packed16", w, 32'h5678_1234);
    check("R4 level", 32'(level_o), 0);
  endtask

  task automatic t_pk8();
    logic [31:0] w;
    mode_i = 2'd2;
    push(32'hFFFF_FFA5, 32'h1234_565A);
    pull(w); check("R5 packed8", w, 32'h0000_5AA5);
    check("R5 level", 32'(level_o), 0);
  endtask

  task automatic t_mono();
    logic [31:0] w;
    mode_i = 2'd3;
    push(32'hCAFE_F00D, 32'h0000_0001);
    check("R6 level two", 32'(level_o), 2);
    pull(w); check("R6 mono word", w, 32'hCAFE_F00D);
    check("R6 level", 32'(level_o), 0);
  endtask

  task automatic t_thr();
    logic [31:0] w;
    set_thr(5'd5); check("R8 readback 5", 32'(thr_o), 5);
    set_thr(5'd4); check("R8 readback 4", 32'(thr_o), 5);
    mode_i = 2'd3;
    push(32'd1, 32'd0); check("R7 level 2 thr 4", 32'(req_o), 0);
    push(32'd2, 32'd0); check("R7 level 4 thr 4", 32'(req_o), 0);
    push(32'd3, 32'd0); check("R7 level 6 thr 4", 32'(req_o), 1);
    set_thr(5'd16); check("R8 readback 16", 32'(thr_o), 17);
    for (int i = 0; i < 5; i++) push(32'd10 + 32'(i), 32'd0);
    check("R7 full thr 16", 32'(req_o), 0);
    set_thr(5'd0); check("R7 thr 0 full", 32'(req_o), 1);
    for (int i = 0; i < 8; i++) pull(w);
    check("R7 thr 0 empty", 32'(req_o), 0);
    push(32'd7, 32'd0); check("R7 thr 0 any data", 32'(req_o), 1);
    pull(w);
  endtask

  task automatic t_overflow();
    logic [31:0] w;
    mode_i = 2'd3;
    for (int i = 0; i < 8; i++) push(32'h100 + 32'(i), 32'd0);
    check("R9 no err at full", 32'(rx_err_o), 0);
    push(32'hBAD0_BAD0, 32'd0);
    check("R9 err set", 32'(rx_err_o), 1);
    check("R2 level capped", 32'(level_o), 16);
    for (int i = 0; i < 8; i++) begin
      pull(w); check("R11 R9 kept order", w, 32'h100 + 32'(i));
    end
    check("R9 err sticky", 32'(rx_err_o), 1);
  endtask

  task automatic t_empty();
    logic [31:0] w;
    pull(w); check("R10 empty data", w, 0);
    check("R10 level", 32'(level_o), 0);
    mode_i = 2'd0;
    pull(w); check("R10 dual empty", 32'(level_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dual();
    t_pk16();
    t_pk8();
    t_mono();
    t_thr();
    t_overflow();
    t_empty();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule